// File: doc/BRIEF.md
# Two-Tone Cadence Sequencer

This block gates two tone sample streams, C and D, produced elsewhere, under a two-phase cadence. The first phase (M0) and the second phase (M1) each last a programmable number of sample strobes. Each tone carries a two-bit code that says in which phases it sounds. The two gated streams are combined in one of two ways: by a saturating sum, or by a Q15 product. The result is driven onto a transmit output and a receive output, and each output has its own enable.

Software writes one 8-bit control byte. In single-shot mode the block plays M0 then M1 once, then clears the control byte to zero by itself. In continuous mode the M0/M1 cycle repeats until software writes zero. While a run is active, only a write of zero is accepted. Any other value is dropped and flagged. After a continuous run stops, a guard interval has to pass before another start is taken. A start is also held off while either the FSK generator or the dial-pulse generator reports busy.

Top module: `tone_cadence_seq`

## Requirements
- R1: The control byte is laid out as follows. Bit 7 enables transmit. Bit 6 enables receive. Bit 5 selects the combine mode (1 = multiply). Bit 4 selects the run mode (1 = continuous). Bits 3:2 are the code for tone C and bits 1:0 are the code for tone D. Any write made while idle is stored and can be read on `ctrl_q` after the write edge.
- R2: A tone code selects when that tone sounds. The high bit enables the tone in M0 and the low bit enables it in M1, so 00 = never, 01 = M1 only, 10 = M0 only, 11 = both. A tone that is gated off contributes the value 0.
- R3: In add mode the output is the sum of the gated 16-bit signed samples, clamped to the range -32768..32767.
- R4: In multiply mode the output is (C*D) arithmetically shifted right by 15, clamped to 32767. The product is formed after gating, so if either tone is off the result is 0.
- R5: Transmit and receive each carry the combined value only when their enable bit is set, and drive 0 otherwise. Outputs are registered one clock after the phase they reflect.
- R6: A single-shot run lasts `tim_m0` sample strobes in M0, then `tim_m1` strobes in M1. On the last strobe, `ctrl_q` becomes 00h and `busy` falls.
- R7: A continuous run cycles M0, M1, M0, and so on until 00h is written. That write ends the run on its own edge.
- R8: During an active run, a nonzero write leaves `ctrl_q` unchanged and sets `wr_reject`. Any accepted write clears `wr_reject`.
- R9: After a continuous run is stopped, no start occurs for `GUARD_CYCLES` clocks. A pending start is then taken.
- R10: While `fsk_busy` or `dp_busy` is high, no run starts. The request stays pending and starts once both inputs are low.
- R11: A phase whose timer value is zero is skipped. If both timer values are zero, a start clears `ctrl_q` to 00h and no run takes place.
- R12: `busy` is high from the clock after the start edge until the run ends.
- R13: Reset clears `ctrl_q`, `busy`, `wr_reject`, `tx_out` and `rx_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| tim_m0 | input | 16 | M0 length in sample strobes |
| tim_m1 | input | 16 | M1 length in sample strobes |
| smp_stb | input | 1 | Sample strobe, advances the phase timer |
| tone_c | input | 16 | Tone C sample, signed |
| tone_d | input | 16 | Tone D sample, signed |
| fsk_busy | input | 1 | FSK generator busy, inhibits start |
| dp_busy | input | 1 | Dial-pulse generator busy, inhibits start |
| ctrl_q | output | 8 | Current control byte |
| busy | output | 1 | Run active |
| wr_reject | output | 1 | Last write was refused |
| tx_out | output | 16 | Transmit sample, signed |
| rx_out | output | 16 | Receive sample, signed |

## Verification
The assertions assume the following about the inputs:
- `tim_m0` and `tim_m1` are held steady while a run is active. If they change mid-run, a continuous run could end with its register cleared, and the lock property would be broken.
- Reset is asserted from time zero.

The stimulus sets both timer values before each write and changes them only between runs. Each run is finished, or stopped and followed by more than the guard time, before the next run is set up. Busy inputs from the neighbouring generators are raised only while the block is idle, which is where the inhibit property applies.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_M0   = 2'd1,
    PH_M1   = 2'd2
  } phase_e;

  localparam int CTRL_W   = 8;
  localparam int BIT_TX   = 7;
  localparam int BIT_RX   = 6;
  localparam int BIT_MUL  = 5;
  localparam int BIT_CONT = 4;
endpackage

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
  import tcs_pkg::*;
#(
  parameter int TIMER_W      = 16,
  parameter int GUARD_W      = 16,
  parameter int GUARD_CYCLES = 31250
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CTRL_W-1:0]  wr_data,
  input  logic [TIMER_W-1:0] tim_m0,
  input  logic [TIMER_W-1:0] tim_m1,
  input  logic               smp_stb,
  input  logic               fsk_busy,
  input  logic               dp_busy,
  output logic [CTRL_W-1:0]  ctrl_q,
  output phase_e             phase_q,
  output logic               wr_reject
);
  localparam logic [GUARD_W-1:0] GUARD_LOAD = GUARD_W'(GUARD_CYCLES);
  localparam logic [TIMER_W-1:0] ONE_T      = TIMER_W'(1);

  logic [TIMER_W-1:0] seg_cnt;
  logic [GUARD_W-1:0] guard_cnt;
  logic run_act, stop_req, wr_ok, start_ok, seg_end;
  logic m0_live, m1_live, cont;

  always_comb begin
    run_act  = (phase_q != PH_IDLE);
    cont     = ctrl_q[BIT_CONT];
    m0_live  = (tim_m0 != '0);
    m1_live  = (tim_m1 != '0);
    wr_ok    = wr_en && (!run_act || (wr_data == '0));
    stop_req = run_act && wr_en && (wr_data == '0);
    start_ok = !run_act && !wr_en && (ctrl_q != '0) && (guard_cnt == '0)
               && !fsk_busy && !dp_busy;
    seg_end  = run_act && smp_stb && (seg_cnt == ONE_T);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      phase_q   <= PH_IDLE;
      seg_cnt   <= '0;
      guard_cnt <= '0;
      wr_reject <= 1'b0;
    end else begin
      if (guard_cnt != '0) guard_cnt <= guard_cnt - GUARD_W'(1);
      if (wr_ok) ctrl_q <= wr_data;
      if (wr_en) wr_reject <= !wr_ok;

      if (stop_req) begin
        phase_q <= PH_IDLE;
        if (cont) guard_cnt <= GUARD_LOAD;
      end else if (start_ok) begin
        if (m0_live) begin
          phase_q <= PH_M0;
          seg_cnt <= tim_m0;
        end else if (m1_live) begin
          phase_q <= PH_M1;
          seg_cnt <= tim_m1;
        end else begin
          ctrl_q <= '0;
        end
      end else if (seg_end) begin
        if (phase_q == PH_M0 && m1_live) begin
          phase_q <= PH_M1;
          seg_cnt <= tim_m1;
        end else if (cont && m0_live && (phase_q == PH_M1 || !m1_live)) begin
          phase_q <= PH_M0;
          seg_cnt <= tim_m0;
        end else if (cont && phase_q == PH_M1 && m1_live) begin
          seg_cnt <= tim_m1;
        end else begin
          phase_q <= PH_IDLE;
          ctrl_q  <= '0;
        end
      end else if (run_act && smp_stb) begin
        seg_cnt <= seg_cnt - ONE_T;
      end
    end
  end
endmodule

// File: rtl/tcs_mix.sv
module tcs_mix
  import tcs_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  phase_e                     phase,
  input  logic [3:0]                 codes,
  input  logic                       mul,
  input  logic                       tx_en,
  input  logic                       rx_en,
  input  logic signed [SAMPLE_W-1:0] tone_c,
  input  logic signed [SAMPLE_W-1:0] tone_d,
  output logic signed [SAMPLE_W-1:0] tx_out,
  output logic signed [SAMPLE_W-1:0] rx_out
);
  localparam int W = SAMPLE_W;
  localparam logic signed [W-1:0]   OUT_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]   OUT_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W:0]     SUM_MAX = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0]     SUM_MIN = {2'b11, {(W-1){1'b0}}};
  localparam logic signed [2*W-1:0] Q_MAX   = {{(W+1){1'b0}}, {(W-1){1'b1}}};

  logic signed [W-1:0] tone_v [2];
  logic        [1:0]   code_v [2];
  logic signed [W-1:0] gated  [2];

  assign tone_v[0] = tone_c;
  assign tone_v[1] = tone_d;
  assign code_v[0] = codes[3:2];
  assign code_v[1] = codes[1:0];

  for (genvar g = 0; g < 2; g++) begin : g_gate
    logic on;
    assign on = (phase == PH_M0 && code_v[g][1]) || (phase == PH_M1 && code_v[g][0]);
    assign gated[g] = on ? tone_v[g] : '0;
  end

  logic signed [W:0]     sum_w;
  logic signed [2*W-1:0] prod_w;
  logic signed [2*W-1:0] shift_w;
  logic signed [W-1:0]   add_v, mul_v, mix_v;

  always_comb begin
    sum_w   = {gated[0][W-1], gated[0]} + {gated[1][W-1], gated[1]};
    prod_w  = gated[0] * gated[1];
    shift_w = prod_w >>> (W-1);
    if (sum_w > SUM_MAX)      add_v = OUT_MAX;
    else if (sum_w < SUM_MIN) add_v = OUT_MIN;
    else                      add_v = sum_w[W-1:0];
    mul_v = (shift_w > Q_MAX) ? OUT_MAX : shift_w[W-1:0];
    mix_v = mul ? mul_v : add_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out <= '0;
      rx_out <= '0;
    end else begin
      tx_out <= tx_en ? mix_v : '0;
      rx_out <= rx_en ? mix_v : '0;
    end
  end
endmodule

// File: rtl/tone_cadence_seq.sv
module tone_cadence_seq
  import tcs_pkg::*;
#(
  parameter int SAMPLE_W     = 16,
  parameter int TIMER_W      = 16,
  parameter int GUARD_W      = 16,
  parameter int GUARD_CYCLES = 31250
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic [TIMER_W-1:0]  tim_m0,
  input  logic [TIMER_W-1:0]  tim_m1,
  input  logic                smp_stb,
  input  logic [SAMPLE_W-1:0] tone_c,
  input  logic [SAMPLE_W-1:0] tone_d,
  input  logic                fsk_busy,
  input  logic                dp_busy,
  output logic [7:0]          ctrl_q,
  output logic                busy,
  output logic                wr_reject,
  output logic [SAMPLE_W-1:0] tx_out,
  output logic [SAMPLE_W-1:0] rx_out
);
  phase_e phase;

  tcs_ctrl #(
    .TIMER_W(TIMER_W),
    .GUARD_W(GUARD_W),
    .GUARD_CYCLES(GUARD_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tim_m0(tim_m0), .tim_m1(tim_m1), .smp_stb(smp_stb),
    .fsk_busy(fsk_busy), .dp_busy(dp_busy),
    .ctrl_q(ctrl_q), .phase_q(phase), .wr_reject(wr_reject)
  );

  assign busy = (phase != PH_IDLE);

  tcs_mix #(.SAMPLE_W(SAMPLE_W)) u_mix (
    .clk(clk), .rst(rst), .phase(phase), .codes(ctrl_q[3:0]),
    .mul(ctrl_q[BIT_MUL]), .tx_en(ctrl_q[BIT_TX]), .rx_en(ctrl_q[BIT_RX]),
    .tone_c(tone_c), .tone_d(tone_d), .tx_out(tx_out), .rx_out(rx_out)
  );
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [7:0]          wr_data,
  input logic                fsk_busy,
  input logic                dp_busy,
  input logic [7:0]          ctrl_q,
  input logic                busy,
  input logic                wr_reject,
  input logic [SAMPLE_W-1:0] tx_out,
  input logic [SAMPLE_W-1:0] rx_out
);
  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (tx_out == '0 && rx_out == '0));

  p_tx_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[7] |=> (tx_out == '0));

  p_rx_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[6] |=> (rx_out == '0));

  p_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && wr_data == 8'h00) |=> (!busy && ctrl_q == 8'h00));

  p_reject_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && wr_data != 8'h00) |=> wr_reject);

  p_lock_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_q[4] && wr_en && wr_data != 8'h00) |=> $stable(ctrl_q));

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en) |=> (!wr_reject && ctrl_q == $past(wr_data)));

  p_inhibit_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && (fsk_busy || dp_busy)) |=> !busy);

  p_selfclear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (ctrl_q == 8'h00));
endmodule

bind tone_cadence_seq tcs_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .fsk_busy(fsk_busy), .dp_busy(dp_busy), .ctrl_q(ctrl_q), .busy(busy),
  .wr_reject(wr_reject), .tx_out(tx_out), .rx_out(rx_out)
);

// File: tb/tone_cadence_seq_tb.sv
`timescale 1ns/1ps
module tone_cadence_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [15:0] tim_m0 = 16'd2;
  logic [15:0] tim_m1 = 16'd3;
  logic smp_stb = 1'b0;
  logic signed [15:0] tone_c = '0;
  logic signed [15:0] tone_d = '0;
  logic fsk_busy = 1'b0;
  logic dp_busy = 1'b0;
  logic [7:0] ctrl_q;
  logic busy, wr_reject;
  logic [15:0] tx_out, rx_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tone_cadence_seq #(.GUARD_CYCLES(20)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tim_m0(tim_m0), .tim_m1(tim_m1), .smp_stb(smp_stb),
    .tone_c(tone_c), .tone_d(tone_d), .fsk_busy(fsk_busy), .dp_busy(dp_busy),
    .ctrl_q(ctrl_q), .busy(busy), .wr_reject(wr_reject),
    .tx_out(tx_out), .rx_out(rx_out)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(input int n);
    repeat (n) begin
      smp_stb = 1'b1;
      @(posedge clk);
      @(negedge clk);
      smp_stb = 1'b0;
    end
  endtask

  function automatic logic [15:0] model(input logic [7:0] cfg, input bit ph1,
                                        input logic signed [15:0] c,
                                        input logic signed [15:0] d);
    bit gc, gd;
    int a, b, r;
    gc = ph1 ? cfg[2] : cfg[3];
    gd = ph1 ? cfg[0] : cfg[1];
    a = gc ? int'(c) : 0;
    b = gd ? int'(d) : 0;
    if (cfg[5]) r = (a * b) >>> 15;
    else        r = a + b;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  // Single-shot run with M0 = 2 strobes, M1 = 3 strobes
  task automatic run_single(input string tag, input logic [7:0] cfg,
                            input logic signed [15:0] c, input logic signed [15:0] d);
    logic [15:0] e0, e1;
    e0 = model(cfg, 1'b0, c, d);
    e1 = model(cfg, 1'b1, c, d);
    tone_c = c;
    tone_d = d;
    wr(cfg);
    check("R1", "stored byte", ctrl_q, cfg);
    tick(2);
    check("R12", "busy in run", busy, 1);
    check(tag, "tx M0", tx_out, cfg[7] ? e0 : 16'h0);
    check("R5", "rx M0", rx_out, cfg[6] ? e0 : 16'h0);
    strobe(1);
    check("R6", "still M0 after 1 strobe", tx_out, cfg[7] ? e0 : 16'h0);
    strobe(1);
    tick(1);
    check(tag, "tx M1", tx_out, cfg[7] ? e1 : 16'h0);
    check("R5", "rx M1", rx_out, cfg[6] ? e1 : 16'h0);
    strobe(2);
    check("R6", "busy before last M1 strobe", busy, 1);
    strobe(1);
    check("R6", "self clear", ctrl_q, 8'h00);
    check("R6", "busy fell", busy, 0);
    tick(1);
    check("R5", "tx quiet after run", tx_out, 16'h0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    check("R13", "ctrl after reset", ctrl_q, 8'h00);
    check("R13", "busy after reset", busy, 0);
    check("R13", "reject after reset", wr_reject, 0);
    check("R13", "tx after reset", tx_out, 16'h0);
    check("R13", "rx after reset", rx_out, 16'h0);

    // R2 sweep: every code pair, both combine modes, varied enables
    for (int k = 0; k < 32; k++) begin
      logic [7:0] cfg;
      cfg = {1'b1, (k % 3 != 0), k[4], 1'b0, k[3:0]};
      run_single("R2", cfg, 16'(k * 1733 - 20000), 16'(31000 - k * 2011));
    end
    run_single("R5", 8'h4F, 16'sd1200, 16'sd34);

    // R3 saturation
    run_single("R3", 8'hCF, 16'sd30000, 16'sd10000);
    run_single("R3", 8'hCF, -16'sd30000, -16'sd10000);
    run_single("R3", 8'hC9, 16'sd7, -16'sd9);
    // R4 products
    run_single("R4", 8'hEF, -16'sd32768, -16'sd32768);
    run_single("R4", 8'hEF, 16'sd16384, 16'sd16384);
    run_single("R4", 8'hEF, -16'sd32768, 16'sd32767);
    run_single("R4", 8'hE9, 16'sd1000, 16'sd1000);

    // R8 during single-shot
    tone_c = 16'sd100;
    wr(8'h8C);
    tick(2);
    wr(8'h12);
    check("R8", "single lock byte", ctrl_q, 8'h8C);
    check("R8", "single lock flag", wr_reject, 1);
    strobe(5);
    check("R6", "cleared after locked run", ctrl_q, 8'h00);

    // R7 continuous alternation, C in M0 and D in M1
    tim_m0 = 16'd2;
    tim_m1 = 16'd1;
    tone_c = 16'sd500;
    tone_d = -16'sd700;
    wr(8'hD9);
    tick(2);
    for (int p = 0; p < 3; p++) begin
      check("R7", "cont M0 tx", tx_out, 16'd500);
      check("R7", "cont M0 rx", rx_out, 16'd500);
      strobe(2);
      tick(1);
      check("R7", "cont M1 tx", tx_out, 16'hFD44);
      strobe(1);
      tick(1);
    end
    check("R7", "cont still busy", busy, 1);
    wr(8'h55);
    check("R8", "cont lock byte", ctrl_q, 8'hD9);
    check("R8", "cont lock flag", wr_reject, 1);
    check("R8", "cont still running", busy, 1);
    tick(1);
    check("R8", "output unchanged", tx_out, 16'd500);
    wr(8'h00);
    check("R7", "stop busy", busy, 0);
    check("R7", "stop byte", ctrl_q, 8'h00);
    check("R8", "flag cleared", wr_reject, 0);
    tick(1);
    check("R7", "stop quiet", tx_out, 16'h0);

    // R9 guard
    wr(8'hD9);
    check("R9", "byte accepted in guard", ctrl_q, 8'hD9);
    tick(5);
    check("R9", "held in guard", busy, 0);
    tick(25);
    check("R9", "start after guard", busy, 1);
    wr(8'h00);
    tick(30);

    // R10 inhibit
    tim_m0 = 16'd2;
    tim_m1 = 16'd3;
    tone_c = 16'sd321;
    fsk_busy = 1'b1;
    wr(8'h8C);
    tick(5);
    check("R10", "fsk inhibit", busy, 0);
    check("R10", "fsk inhibit tx", tx_out, 16'h0);
    fsk_busy = 1'b0;
    tick(1);
    check("R10", "start after fsk", busy, 1);
    tick(1);
    check("R10", "tx after fsk", tx_out, 16'd321);
    strobe(5);
    dp_busy = 1'b1;
    wr(8'h8C);
    tick(5);
    check("R10", "dp inhibit", busy, 0);
    dp_busy = 1'b0;
    tick(1);
    check("R10", "start after dp", busy, 1);
    strobe(5);
    check("R10", "dp run done", ctrl_q, 8'h00);

    // R11 zero-length phases
    tim_m0 = 16'd0;
    tim_m1 = 16'd2;
    tone_c = 16'sd1234;
    wr(8'h84);
    tick(2);
    check("R11", "M0 skipped", tx_out, 16'd1234);
    strobe(2);
    check("R11", "M1-only run done", ctrl_q, 8'h00);
    tim_m1 = 16'd0;
    wr(8'h8C);
    tick(2);
    check("R11", "empty clears", ctrl_q, 8'h00);
    check("R11", "empty never busy", busy, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule